// File: doc/BRIEF.md
# Boundary-scan octal latch

An eight-bit transparent latch with an active-low output enable, wrapped in 1149.1-style boundary-scan test logic. In the normal modes the latch passes its data inputs to its outputs while the latch enable is high and holds them while it is low. A disabled output is modelled by dropping the `q_valid` flag in place of a real high-impedance pad. While a normal-mode instruction is loaded, scan traffic on the four-wire test port may sample the pins without disturbing the latch.

Loading a test instruction moves the block into test mode. The boundary cells then drive the outputs, feed the core latch, or observe the pins. Three extra modes run on every TCK rising edge spent in Run-Test/Idle:
- **Signature compression:** the data inputs are folded into a signature.
- **Pattern generation:** the outputs step through a pseudo-random sequence.
- **Output toggling:** the driven output values are inverted.

The test controller has sixteen states: Test-Logic-Reset, Run-Test/Idle, Select-DR-Scan, Capture-DR, Shift-DR, Exit1-DR, Pause-DR, Exit2-DR, Update-DR, and the six matching -IR states after Select-IR-Scan. The transitions, with TMS high / TMS low, are:

| State | TMS high | TMS low |
|---|---|---|
| Test-Logic-Reset | Test-Logic-Reset | Run-Test/Idle |
| Run-Test/Idle | Select-DR-Scan | Run-Test/Idle |
| Select-DR-Scan | Select-IR-Scan | Capture-DR |
| Select-IR-Scan | Test-Logic-Reset | Capture-IR |
| Capture-xR | Exit1-xR | Shift-xR |
| Shift-xR | Exit1-xR | Shift-xR |
| Exit1-xR | Update-xR | Pause-xR |
| Pause-xR | Exit2-xR | Pause-xR |
| Exit2-xR | Update-xR | Shift-xR |
| Update-xR | Select-DR-Scan | Run-Test/Idle |

Capture, shift, update and the Run-Test/Idle actions all happen on the TCK rising edge that leaves the named state.

Top module: `bscan_latch8`

## Requirements
- R1: In a normal-mode instruction (bypass, sample/preload or any undefined opcode), with `oe_n` low and `le` high, `q_out` equals `d_in` and `q_valid` is 1.
- R2: In a normal-mode instruction with `le` low, `q_out` keeps its value whatever `d_in` does.
- R3: In a normal-mode instruction with `oe_n` high, `q_valid` is 0 whatever `le` and `d_in` are.
- R4: A low `trst_n` puts the controller in Test-Logic-Reset at once. Five TCK edges with TMS high also reach it from any state. In Test-Logic-Reset the bypass instruction is in force. Opcode 8'hFF and every opcode not listed in R6 to R13 select a one-bit bypass register that captures 0.
- R5: The 8-bit instruction register captures 8'b10000001 in Capture-IR. Both registers shift least significant bit first, from `tdi` toward `tdo`. `tdo` changes on the falling TCK edge and reads 0 outside the Shift states.
- R6: Sample/preload (8'h01) selects an 18-bit boundary register. Counting from the `tdo` end, bits 0-7 hold the latch outputs, bits 8-15 the data inputs, bit 16 `le` and bit 17 `oe_n`; Capture-DR loads them. The latch keeps its normal behaviour throughout.
- R7: Extest (8'h00) drives `q_out` from update bits 0-7 and `q_valid` from the inverse of update bit 17.
- R8: Intest (8'h02) feeds the core latch from update bits 8-15 (data) and 16 (enable). The pins are driven as in R7, and Capture-DR bits 0-7 read the latch output.
- R9: Clamp (8'h03) drives the outputs as in R7 from the held update cells and selects the bypass register.
- R10: Highz (8'h04) forces `q_valid` to 0 and selects the bypass register.
- R11: Signature (8'h05): on each Run-Test/Idle edge, update bits 8-15 (S) become {S[6:0], S[7]^S[5]^S[4]^S[3]} XOR `d_in`. In this mode Capture-DR bits 8-15 read S.
- R12: Pattern (8'h06): on each Run-Test/Idle edge, update bits 0-7 advance by the same shift-and-feedback step. A zero value steps to 8'h01. Outputs are driven as in R7.
- R13: Toggle (8'h07): on each Run-Test/Idle edge, update bits 0-7 are inverted. Outputs are driven as in R7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous test reset, active low |
| tms | input | 1 | Test mode select |
| tdi | input | 1 | Serial test data in |
| tdo | output | 1 | Serial test data out, falling-edge timed |
| d_in | input | 8 | Latch data inputs |
| le | input | 1 | Latch enable, transparent when high |
| oe_n | input | 1 | Output enable, active low |
| q_out | output | 8 | Latch data outputs |
| q_valid | output | 1 | Low when the outputs are in high impedance |

## Verification
The hardest state to reach is a known signature. It depends on the seed scanned in, on every `d_in` value present at each Run-Test/Idle edge, and on the extra step taken on the edge that leaves Run-Test/Idle for the read-back scan. The bench seeds the signature through a full data scan and then walks a counted number of idle edges with fresh random inputs on each. It models the exit edge explicitly and compares the scanned-out bits 8-15. Pattern generation is started from an all-zero seed so that the escape to 8'h01 is exercised.

// File: rtl/bscan_pkg.sv
package bscan_pkg;

    typedef enum logic [3:0] {
        TS_RESET, TS_IDLE,
        TS_SEL_DR, TS_CAP_DR, TS_SH_DR, TS_EX1_DR, TS_PAU_DR, TS_EX2_DR, TS_UPD_DR,
        TS_SEL_IR, TS_CAP_IR, TS_SH_IR, TS_EX1_IR, TS_PAU_IR, TS_EX2_IR, TS_UPD_IR
    } tap_state_e;

    typedef enum logic [3:0] {
        MD_PASS, MD_SAMPLE, MD_EXTEST, MD_INTEST, MD_CLAMP,
        MD_HIGHZ, MD_SIGN, MD_PATGEN, MD_TOGGLE
    } mode_e;

    localparam int          IR_W       = 8;
    localparam logic [7:0]  IR_CAPTURE = 8'b1000_0001;
    localparam logic [7:0]  OP_EXTEST  = 8'h00;
    localparam logic [7:0]  OP_SAMPLE  = 8'h01;
    localparam logic [7:0]  OP_INTEST  = 8'h02;
    localparam logic [7:0]  OP_CLAMP   = 8'h03;
    localparam logic [7:0]  OP_HIGHZ   = 8'h04;
    localparam logic [7:0]  OP_SIGN    = 8'h05;
    localparam logic [7:0]  OP_PATGEN  = 8'h06;
    localparam logic [7:0]  OP_TOGGLE  = 8'h07;
    localparam logic [7:0]  OP_BYPASS  = 8'hFF;

endpackage

// File: rtl/bscan_tap_fsm.sv
module bscan_tap_fsm
    import bscan_pkg::*;
(
    input  logic       tck,
    input  logic       trst_n,
    input  logic       tms,
    output tap_state_e state,
    output logic       in_reset,
    output logic       in_idle,
    output logic       cap_dr,
    output logic       sh_dr,
    output logic       upd_dr,
    output logic       cap_ir,
    output logic       sh_ir,
    output logic       upd_ir
);

    tap_state_e nxt;

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) state <= TS_RESET;
        else         state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            TS_RESET:  nxt = tms ? TS_RESET  : TS_IDLE;
            TS_IDLE:   nxt = tms ? TS_SEL_DR : TS_IDLE;
            TS_SEL_DR: nxt = tms ? TS_SEL_IR : TS_CAP_DR;
            TS_CAP_DR: nxt = tms ? TS_EX1_DR : TS_SH_DR;
            TS_SH_DR:  nxt = tms ? TS_EX1_DR : TS_SH_DR;
            TS_EX1_DR: nxt = tms ? TS_UPD_DR : TS_PAU_DR;
            TS_PAU_DR: nxt = tms ? TS_EX2_DR : TS_PAU_DR;
            TS_EX2_DR: nxt = tms ? TS_UPD_DR : TS_SH_DR;
            TS_UPD_DR: nxt = tms ? TS_SEL_DR : TS_IDLE;
            TS_SEL_IR: nxt = tms ? TS_RESET  : TS_CAP_IR;
            TS_CAP_IR: nxt = tms ? TS_EX1_IR : TS_SH_IR;
            TS_SH_IR:  nxt = tms ? TS_EX1_IR : TS_SH_IR;
            TS_EX1_IR: nxt = tms ? TS_UPD_IR : TS_PAU_IR;
            TS_PAU_IR: nxt = tms ? TS_EX2_IR : TS_PAU_IR;
            TS_EX2_IR: nxt = tms ? TS_UPD_IR : TS_SH_IR;
            TS_UPD_IR: nxt = tms ? TS_SEL_DR : TS_IDLE;
            default:   nxt = TS_RESET;
        endcase
    end

    always_comb begin
        in_reset = (state == TS_RESET);
        in_idle  = (state == TS_IDLE);
        cap_dr   = (state == TS_CAP_DR);
        sh_dr    = (state == TS_SH_DR);
        upd_dr   = (state == TS_UPD_DR);
        cap_ir   = (state == TS_CAP_IR);
        sh_ir    = (state == TS_SH_IR);
        upd_ir   = (state == TS_UPD_IR);
    end

endmodule

// File: rtl/bscan_instr.sv
module bscan_instr
    import bscan_pkg::*;
(
    input  logic  tck,
    input  logic  trst_n,
    input  logic  tdi,
    input  logic  in_reset,
    input  logic  cap_ir,
    input  logic  sh_ir,
    input  logic  upd_ir,
    output logic  ser_out,
    output mode_e mode,
    output logic  use_bsr
);

    logic [IR_W-1:0] ir_sh;
    logic [IR_W-1:0] ir_held;
    logic [IR_W-1:0] ir_eff;

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n)     ir_sh <= IR_CAPTURE;
        else if (cap_ir) ir_sh <= IR_CAPTURE;
        else if (sh_ir)  ir_sh <= {tdi, ir_sh[IR_W-1:1]};
    end

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n)       ir_held <= OP_BYPASS;
        else if (in_reset) ir_held <= OP_BYPASS;
        else if (upd_ir)   ir_held <= ir_sh;
    end

    assign ser_out = ir_sh[0];
    assign ir_eff  = in_reset ? OP_BYPASS : ir_held;

    always_comb begin
        unique case (ir_eff)
            OP_EXTEST: mode = MD_EXTEST;
            OP_SAMPLE: mode = MD_SAMPLE;
            OP_INTEST: mode = MD_INTEST;
            OP_CLAMP:  mode = MD_CLAMP;
            OP_HIGHZ:  mode = MD_HIGHZ;
            OP_SIGN:   mode = MD_SIGN;
            OP_PATGEN: mode = MD_PATGEN;
            OP_TOGGLE: mode = MD_TOGGLE;
            default:   mode = MD_PASS;
        endcase
        use_bsr = !(mode == MD_PASS || mode == MD_CLAMP || mode == MD_HIGHZ);
    end

endmodule

// File: rtl/bscan_bsr.sv
module bscan_bsr
    import bscan_pkg::*;
#(
    parameter int             NCH  = 8,
    parameter logic [NCH-1:0] TAPS = 'hB8
) (
    input  logic           tck,
    input  logic           trst_n,
    input  logic           tdi,
    input  logic           cap,
    input  logic           shift,
    input  logic           update,
    input  logic           in_idle,
    input  mode_e          mode,
    input  logic [NCH-1:0] d_pin,
    input  logic           le_pin,
    input  logic           oe_pin,
    input  logic [NCH-1:0] core_q,
    output logic           ser_out,
    output logic [NCH-1:0] upd_q,
    output logic [NCH-1:0] upd_d,
    output logic           upd_le,
    output logic           upd_oe
);

    localparam int LEN   = 2 * NCH + 2;
    localparam int D_LO  = NCH;
    localparam int LE_AT = 2 * NCH;
    localparam int OE_AT = 2 * NCH + 1;

    logic [LEN-1:0] sh;
    logic [LEN-1:0] upd;
    logic [LEN-1:0] cap_val;

    function automatic logic [NCH-1:0] lfsr_step(input logic [NCH-1:0] s);
        return {s[NCH-2:0], ^(s & TAPS)};
    endfunction

    for (genvar i = 0; i < NCH; i++) begin : g_cell
        assign cap_val[i]        = core_q[i];
        assign cap_val[D_LO + i] = (mode == MD_SIGN) ? upd[D_LO + i] : d_pin[i];
    end
    assign cap_val[LE_AT] = le_pin;
    assign cap_val[OE_AT] = oe_pin;

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n)    sh <= '0;
        else if (cap)   sh <= cap_val;
        else if (shift) sh <= {tdi, sh[LEN-1:1]};
    end

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) begin
            upd <= '0;
        end else if (update) begin
            upd <= sh;
        end else if (in_idle) begin
            unique case (mode)
                MD_SIGN:
                    upd[D_LO +: NCH] <= lfsr_step(upd[D_LO +: NCH]) ^ d_pin;
                MD_PATGEN:
                    upd[NCH-1:0] <= (upd[NCH-1:0] == '0) ? NCH'(1)
                                                         : lfsr_step(upd[NCH-1:0]);
                MD_TOGGLE:
                    upd[NCH-1:0] <= ~upd[NCH-1:0];
                default: ;
            endcase
        end
    end

    assign ser_out = sh[0];
    assign upd_q   = upd[NCH-1:0];
    assign upd_d   = upd[D_LO +: NCH];
    assign upd_le  = upd[LE_AT];
    assign upd_oe  = upd[OE_AT];

endmodule

// File: rtl/bscan_core_latch.sv
module bscan_core_latch #(
    parameter int NCH = 8
) (
    input  logic           le,
    input  logic [NCH-1:0] d,
    output logic [NCH-1:0] q
);

    always_latch begin
        if (le) q <= d;
    end

endmodule

// File: rtl/bscan_latch8.sv
module bscan_latch8
    import bscan_pkg::*;
#(
    parameter int             NCH       = 8,
    parameter logic [NCH-1:0] LFSR_TAPS = 'hB8
) (
    input  logic           tck,
    input  logic           trst_n,
    input  logic           tms,
    input  logic           tdi,
    output logic           tdo,
    input  logic [NCH-1:0] d_in,
    input  logic           le,
    input  logic           oe_n,
    output logic [NCH-1:0] q_out,
    output logic           q_valid
);

    tap_state_e     tap_st;
    logic           in_reset, in_idle;
    logic           cap_dr, sh_dr, upd_dr, cap_ir, sh_ir, upd_ir;
    mode_e          mode;
    logic           use_bsr;
    logic           ir_ser, bsr_ser, byp_q;
    logic [NCH-1:0] b_upd_q, b_upd_d;
    logic           b_upd_le, b_upd_oe;
    logic [NCH-1:0] core_d, core_q;
    logic           core_le;

    bscan_tap_fsm u_tap (
        .tck(tck), .trst_n(trst_n), .tms(tms), .state(tap_st),
        .in_reset(in_reset), .in_idle(in_idle),
        .cap_dr(cap_dr), .sh_dr(sh_dr), .upd_dr(upd_dr),
        .cap_ir(cap_ir), .sh_ir(sh_ir), .upd_ir(upd_ir)
    );

    bscan_instr u_ir (
        .tck(tck), .trst_n(trst_n), .tdi(tdi), .in_reset(in_reset),
        .cap_ir(cap_ir), .sh_ir(sh_ir), .upd_ir(upd_ir),
        .ser_out(ir_ser), .mode(mode), .use_bsr(use_bsr)
    );

    bscan_bsr #(.NCH(NCH), .TAPS(LFSR_TAPS)) u_bsr (
        .tck(tck), .trst_n(trst_n), .tdi(tdi),
        .cap(cap_dr && use_bsr), .shift(sh_dr && use_bsr),
        .update(upd_dr && use_bsr), .in_idle(in_idle), .mode(mode),
        .d_pin(d_in), .le_pin(le), .oe_pin(oe_n), .core_q(core_q),
        .ser_out(bsr_ser), .upd_q(b_upd_q), .upd_d(b_upd_d),
        .upd_le(b_upd_le), .upd_oe(b_upd_oe)
    );

    always_comb begin
        if (mode == MD_INTEST) begin
            core_d  = b_upd_d;
            core_le = b_upd_le;
        end else begin
            core_d  = d_in;
            core_le = le;
        end
    end

    bscan_core_latch #(.NCH(NCH)) u_core (.le(core_le), .d(core_d), .q(core_q));

    always_comb begin
        unique case (mode)
            MD_PASS, MD_SAMPLE: begin
                q_out   = core_q;
                q_valid = !oe_n;
            end
            MD_HIGHZ: begin
                q_out   = '0;
                q_valid = 1'b0;
            end
            default: begin
                q_out   = b_upd_q;
                q_valid = !b_upd_oe;
            end
        endcase
    end

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n)                 byp_q <= 1'b0;
        else if (cap_dr && !use_bsr) byp_q <= 1'b0;
        else if (sh_dr && !use_bsr)  byp_q <= tdi;
    end

    always_ff @(negedge tck or negedge trst_n) begin
        if (!trst_n)    tdo <= 1'b0;
        else if (sh_ir) tdo <= ir_ser;
        else if (sh_dr) tdo <= use_bsr ? bsr_ser : byp_q;
        else            tdo <= 1'b0;
    end

endmodule

// File: rtl/bscan_latch8_chk.sv
module bscan_latch8_chk
    import bscan_pkg::*;
#(
    parameter int NCH = 8
) (
    input logic           tck,
    input logic           trst_n,
    input logic           tms,
    input logic [NCH-1:0] d_in,
    input logic           le,
    input logic           oe_n,
    input logic [NCH-1:0] q_out,
    input logic           q_valid,
    input tap_state_e     tap_st,
    input mode_e          mode
);

    logic norm;
    assign norm = (mode == MD_PASS) || (mode == MD_SAMPLE);

    a_r1_follow: assert property (@(posedge tck) disable iff (!trst_n)
        (norm && le && !oe_n) |-> (q_out == d_in && q_valid));

    a_r2_hold: assert property (@(posedge tck) disable iff (!trst_n)
        (norm && $past(norm) && !le && $past(!le)) |-> $stable(q_out));

    a_r3_disabled: assert property (@(posedge tck) disable iff (!trst_n)
        (norm && oe_n) |-> !q_valid);

    a_r4_five_high: assert property (@(posedge tck) disable iff (!trst_n)
        (tms && $past(tms) && $past(tms, 2) && $past(tms, 3) && $past(tms, 4))
        |=> (tap_st == TS_RESET));

    a_r4_reset_mode: assert property (@(posedge tck) disable iff (!trst_n)
        (tap_st == TS_RESET) |-> (mode == MD_PASS));

    a_r9_clamp_held: assert property (@(posedge tck) disable iff (!trst_n)
        (mode == MD_CLAMP && $past(mode == MD_CLAMP)) |-> $stable(q_out));

    a_r10_highz: assert property (@(posedge tck) disable iff (!trst_n)
        (mode == MD_HIGHZ) |-> !q_valid);

    a_r12_no_lock: assert property (@(posedge tck) disable iff (!trst_n)
        (mode == MD_PATGEN && tap_st == TS_IDLE) |=> (q_out != '0));

    a_r13_invert: assert property (@(posedge tck) disable iff (!trst_n)
        (mode == MD_TOGGLE && tap_st == TS_IDLE) |=> (q_out == ~$past(q_out)));

endmodule

bind bscan_latch8 bscan_latch8_chk #(.NCH(NCH)) i_chk (
    .tck(tck), .trst_n(trst_n), .tms(tms), .d_in(d_in), .le(le),
    .oe_n(oe_n), .q_out(q_out), .q_valid(q_valid),
    .tap_st(tap_st), .mode(mode)
);

// File: tb/test_bscan_latch8.sv
module test_bscan_latch8;

    logic       tck = 1'b0;
    logic       trst_n = 1'b0;
    logic       tms = 1'b1;
    logic       tdi = 1'b0;
    logic       tdo;
    logic [7:0] d_in = 8'h00;
    logic       le = 1'b1;
    logic       oe_n = 1'b0;
    logic [7:0] q_out;
    logic       q_valid;

    int  n_checks = 0;
    int  n_fail   = 0;
    bit  finished = 0;

    always #5 tck = ~tck;

    bscan_latch8 i_bscan_latch8 (
        .tck(tck), .trst_n(trst_n), .tms(tms), .tdi(tdi), .tdo(tdo),
        .d_in(d_in), .le(le), .oe_n(oe_n), .q_out(q_out), .q_valid(q_valid)
    );

    function automatic logic [7:0] lf(input logic [7:0] s);
        return {s[6:0], s[7] ^ s[5] ^ s[4] ^ s[3]};
    endfunction

    task automatic check(input bit ok, input string req,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step(input logic m, input logic di, output logic o);
        @(negedge tck);
        #1;
        o   = tdo;
        tms = m;
        tdi = di;
        @(posedge tck);
        #1;
    endtask

    task automatic scan(input bit is_ir, input int n, input logic [31:0] vin,
                        output logic [31:0] vout);
        logic o;
        vout = '0;
        step(1'b1, 1'b0, o);
        if (is_ir) step(1'b1, 1'b0, o);
        step(1'b0, 1'b0, o);
        step(1'b0, 1'b0, o);
        for (int i = 0; i < n; i++) begin
            step(i == n - 1, vin[i], o);
            vout[i] = o;
        end
        step(1'b1, 1'b0, o);
        step(1'b0, 1'b0, o);
    endtask

    initial begin
        #2_000_000;
        if (!finished) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog actual=%h expected=%h", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic        o;
        logic [31:0] so;
        logic [31:0] pv;
        logic [7:0]  a, sig, pat, v;
        void'($urandom(32'd2024));

        #22 trst_n = 1'b1;
        #2;
        // R1 / R5: reset state
        check(q_valid === 1'b1 && q_out === d_in, "R1 reset", {q_valid, q_out}, {1'b1, d_in});
        check(tdo === 1'b0, "R5 tdo reset", tdo, 0);
        step(1'b0, 1'b0, o);

        for (int i = 0; i < 6; i++) begin
            d_in = 8'($urandom);
            #2;
            check(q_out === d_in && q_valid === 1'b1, "R1 follow", q_out, d_in);
        end

        // R2 hold
        a = 8'($urandom); d_in = a; #2; le = 1'b0;
        for (int i = 0; i < 4; i++) begin
            d_in = 8'($urandom);
            #2;
            check(q_out === a, "R2 hold", q_out, a);
        end

        // R3 disabled
        oe_n = 1'b1; #2;
        check(q_valid === 1'b0, "R3 oe high", q_valid, 0);
        le = 1'b1; #2;
        check(q_valid === 1'b0, "R3 oe high le high", q_valid, 0);
        oe_n = 1'b0; #2;

        // R5 instruction capture, select sample/preload
        scan(1'b1, 8, 32'h01, so);
        check(so[7:0] === 8'h81, "R5 ir capture", so[7:0], 8'h81);

        // R6 sample with latch transparent
        d_in = 8'h3C; le = 1'b1; #2;
        pv = {1'b0, 1'b0, 8'h00, 8'hA5};
        scan(1'b0, 18, pv, so);
        check(so[17:0] === {1'b0, 1'b1, 8'h3C, 8'h3C}, "R6 capture", so[17:0],
              {1'b0, 1'b1, 8'h3C, 8'h3C});
        d_in = 8'hC3; #2;
        check(q_out === 8'hC3 && q_valid === 1'b1, "R6 normal kept", q_out, 8'hC3);

        // R7 extest drives preloaded pattern
        scan(1'b1, 8, 32'h00, so);
        check(q_out === 8'hA5 && q_valid === 1'b1, "R7 extest drive", q_out, 8'hA5);
        d_in = 8'h11; #2;
        check(q_out === 8'hA5, "R7 pins ignored", q_out, 8'hA5);
        scan(1'b0, 18, {1'b1, 1'b0, 8'h00, 8'h5E}, so);
        check(q_out === 8'h5E && q_valid === 1'b0, "R7 extest disable", {q_valid, q_out}, {1'b0, 8'h5E});

        // R8 intest
        scan(1'b1, 8, 32'h02, so);
        scan(1'b0, 18, {1'b0, 1'b1, 8'h96, 8'h0F}, so);
        check(q_out === 8'h0F && q_valid === 1'b1, "R8 pins from cells", q_out, 8'h0F);
        d_in = 8'h44; #2;
        scan(1'b0, 18, {1'b0, 1'b1, 8'h96, 8'h0F}, so);
        check(so[7:0] === 8'h96, "R8 core via cells", so[7:0], 8'h96);
        check(so[15:8] === 8'h44, "R8 input capture", so[15:8], 8'h44);

        // R9 clamp
        scan(1'b1, 8, 32'h03, so);
        check(q_out === 8'h0F && q_valid === 1'b1, "R9 clamp drive", q_out, 8'h0F);
        scan(1'b0, 2, 32'h3, so);
        check(so[1:0] === 2'b10, "R9 bypass path", so[1:0], 2'b10);
        check(q_out === 8'h0F, "R9 held", q_out, 8'h0F);

        // R10 highz
        scan(1'b1, 8, 32'h04, so);
        check(q_valid === 1'b0, "R10 highz", q_valid, 0);
        scan(1'b0, 3, 32'h5, so);
        check(so[2:0] === 3'b010, "R10 bypass path", so[2:0], 3'b010);

        // R4 undefined opcode acts as bypass, normal latch
        scan(1'b1, 8, 32'h5A, so);
        d_in = 8'h77; #2;
        check(q_out === 8'h77 && q_valid === 1'b1, "R4 undefined normal", q_out, 8'h77);
        scan(1'b0, 2, 32'h1, so);
        check(so[1:0] === 2'b10, "R4 undefined bypass", so[1:0], 2'b10);

        // R4 five TMS high from extest
        scan(1'b1, 8, 32'h00, so);
        check(q_out === 8'h0F, "R4 extest before reset", q_out, 8'h0F);
        for (int i = 0; i < 5; i++) step(1'b1, 1'b0, o);
        d_in = 8'hE1; #2;
        check(q_out === 8'hE1 && q_valid === 1'b1, "R4 tms reset", q_out, 8'hE1);
        step(1'b0, 1'b0, o);

        // R4 asynchronous reset out of highz
        scan(1'b1, 8, 32'h04, so);
        check(q_valid === 1'b0, "R10 before trst", q_valid, 0);
        @(negedge tck); #2; trst_n = 1'b0; #1;
        check(q_valid === 1'b1 && q_out === d_in, "R4 trst", {q_valid, q_out}, {1'b1, d_in});
        tms = 1'b1; #3; trst_n = 1'b1;
        step(1'b0, 1'b0, o);

        // R11 signature
        scan(1'b1, 8, 32'h05, so);
        sig = 8'($urandom);
        scan(1'b0, 18, {1'b0, 1'b0, sig, 8'h00}, so);
        for (int i = 0; i < 9; i++) begin
            d_in = 8'($urandom);
            sig  = lf(sig) ^ d_in;
            step(1'b0, 1'b0, o);
        end
        sig = lf(sig) ^ d_in;
        scan(1'b0, 18, 32'h0, so);
        check(so[15:8] === sig, "R11 signature", so[15:8], sig);

        // R12 pattern generator from zero seed
        scan(1'b1, 8, 32'h06, so);
        scan(1'b0, 18, {1'b0, 1'b0, 8'h00, 8'h00}, so);
        check(q_out === 8'h00, "R12 seed zero", q_out, 0);
        step(1'b0, 1'b0, o);
        check(q_out === 8'h01, "R12 zero escape", q_out, 8'h01);
        pat = 8'h01;
        for (int i = 0; i < 12; i++) begin
            step(1'b0, 1'b0, o);
            pat = lf(pat);
            check(q_out === pat && q_valid === 1'b1, "R12 sequence", q_out, pat);
        end

        // R13 toggle
        scan(1'b1, 8, 32'h07, so);
        v = 8'($urandom);
        scan(1'b0, 18, {1'b0, 1'b0, 8'h00, v}, so);
        check(q_out === v, "R13 start", q_out, v);
        for (int i = 0; i < 4; i++) begin
            step(1'b0, 1'b0, o);
            v = ~v;
            check(q_out === v, "R13 invert", q_out, v);
        end

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

endmodule